// File: doc/BRIEF.md
# Windowed Rotating Register Mapper

This block turns an architectural integer register number (0 to 127) into an index into a 128-entry physical register file. The low 32 numbers form a global region that always passes straight through. The upper 96 physical entries form a circular stack of procedure frames. Each frame has a total size, a local part at its bottom and an output part above it. A call moves the frame base up by the caller's local size, so the caller's outputs become the callee's first stacked registers. A return restores the saved caller frame from a bounded save stack. The callee sets its own sizes with an allocate operation.

At the bottom of the current frame there is an optional rotating region, a whole number of 8-register groups. Offsets inside it are shifted by a rotation base modulo the region size, and a loop-branch pulse steps that base down by one. This lets successive loop iterations see renamed registers.

The mapper counts how many stacked registers are resident. It pulses an overflow flag when an allocation needs more than the 96 physical entries. It pulses an underflow flag when a return needs caller locals that have already left the stack. Moving data to and from memory, and the register storage itself, belong to other blocks.

Top module: `win_reg_mapper`

## Requirements
- R1: An architectural number below 32 yields phys_o equal to that number with illegal_o low, on the first rising edge after arch_i is applied.
- R2: For a stacked number 32+o, with o below the frame size and outside the rotating region, phys_o is 32 + ((base + o) mod 96), wrapping around the circular stack.
- R3: A stacked number whose offset o is at or beyond the current frame size gives illegal_o high and phys_o zero.
- R4: An allocate sets the frame size, the local size and the rotating size (alloc_rot_i × 8), and clears the rotation base. It is rejected with no state change when the local size exceeds the frame size, the rotating size exceeds the frame size, or the frame size exceeds 96.
- R5: A call saves the frame and sets base to (base + local size) mod 96, frame size to (frame size − local size), and local size, rotating size and rotation base to zero. A call while 8 frames are already saved is ignored.
- R6: A return restores the most recently saved frame, including its rotation base. A return with no saved frame is ignored.
- R7: For an offset o below the rotating size S, the offset used is (o + rotation base) mod S before the base is added.
- R8: A loop-branch pulse decrements the rotation base, wrapping from 0 to S−1. It has no effect when S is zero.
- R9: When an allocate would raise the resident count (resident − old size + new size) above 96, overflow_o pulses for one cycle after the edge. The frame is still applied and the resident count is clamped to 96. An allocate that reaches exactly 96 raises no flag.
- R10: When a return finds fewer resident registers below the callee frame than the caller's local size, underflow_o pulses for one cycle after the edge. The resident count becomes the caller's frame size.
- R11: Only one operation is applied per cycle, chosen by the priority call, then return, then allocate, then loop branch. The request with the highest priority takes the cycle even when that request is itself ignored.
- R12: After reset, base, sizes, rotation base and resident count are zero and no frame is saved, so every stacked number is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arch_i | input | 7 | Architectural register number to translate |
| call_i | input | 1 | Call request pulse |
| ret_i | input | 1 | Return request pulse |
| alloc_i | input | 1 | Allocate request pulse |
| alloc_sof_i | input | 7 | Requested frame size |
| alloc_sol_i | input | 7 | Requested local size |
| alloc_rot_i | input | 4 | Requested rotating size in groups of 8 |
| loop_br_i | input | 1 | Loop-branch pulse stepping the rotation base |
| phys_o | output | 7 | Physical register index (registered) |
| illegal_o | output | 1 | Offset outside current frame (registered) |
| overflow_o | output | 1 | Stack overflow pulse (registered) |
| underflow_o | output | 1 | Stack underflow pulse (registered) |

## Verification
A translation appears one edge after arch_i is applied. It uses the frame as it stood before that edge, so an operation that changes the frame is visible to a lookup driven in the cycle after the operation. The overflow and underflow pulses appear on the same edge that applies the operation and last exactly one cycle. The bench drives every input on a falling edge and reads the flags on the very next falling edge. For each translation it holds arch_i across one rising edge and samples on the falling edge that follows, so every result is read one register stage after its cause.

// File: rtl/wrm_pkg.sv
package wrm_pkg;
  localparam int unsigned NUM_REGS = 128;
  localparam int unsigned GLOBAL   = 32;
  localparam int unsigned STACK    = NUM_REGS - GLOBAL;
  localparam int unsigned FW       = $clog2(NUM_REGS);
  localparam int unsigned RW       = $clog2(STACK / 8 + 1);

  typedef struct packed {
    logic [FW-1:0] base;
    logic [FW-1:0] sof;
    logic [FW-1:0] sol;
    logic [FW-1:0] sor;
    logic [FW-1:0] rrb;
  } frame_t;
endpackage

// File: rtl/wrm_frame_stack.sv
module wrm_frame_stack
  import wrm_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   push_i,
  input  logic   pop_i,
  input  frame_t push_data_i,
  output frame_t top_o,
  output logic   full_o,
  output logic   empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  frame_t        mem [DEPTH];
  logic [CW-1:0] depth;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] top_idx;

  assign wr_idx  = PW'(depth);
  assign top_idx = (depth == '0) ? '0 : PW'(depth - CW'(1));
  assign full_o  = (depth == CW'(DEPTH));
  assign empty_o = (depth == '0);
  assign top_o   = mem[top_idx];

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_idx] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst)         depth <= '0;
    else if (push_i) depth <= depth + CW'(1);
    else if (pop_i)  depth <= depth - CW'(1);
  end

  assert_depth_bound_R5: assert property (@(posedge clk) disable iff (rst)
    depth <= CW'(DEPTH));
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> (depth != '0) && !push_i);
  assert_push_room_R5: assert property (@(posedge clk) disable iff (rst)
    push_i |-> depth < CW'(DEPTH));
endmodule

// File: rtl/wrm_frame_ctrl.sv
module wrm_frame_ctrl
  import wrm_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          alloc_i,
  input  logic [FW-1:0] alloc_sof_i,
  input  logic [FW-1:0] alloc_sol_i,
  input  logic [RW-1:0] alloc_rot_i,
  input  logic          loop_br_i,
  input  logic          full_i,
  input  logic          empty_i,
  input  frame_t        top_i,
  output logic          push_o,
  output logic          pop_o,
  output frame_t        cur_o,
  output logic          overflow_o,
  output logic          underflow_o
);
  localparam int unsigned XW = FW + 1;

  frame_t        cur, cur_n;
  logic [XW-1:0] live, live_n;
  logic          ovf_n, unf_n;
  logic [XW-1:0] rot_sz, new_live, below, sum_base;
  logic          alloc_ok, do_alloc, do_loop;

  always_comb begin
    rot_sz   = XW'({alloc_rot_i, 3'b000});
    alloc_ok = ({1'b0, alloc_sof_i} <= XW'(STACK)) &&
               (alloc_sol_i <= alloc_sof_i) &&
               (rot_sz <= {1'b0, alloc_sof_i});
    push_o   = call_i && !full_i;
    pop_o    = !call_i && ret_i && !empty_i;
    do_alloc = !call_i && !ret_i && alloc_i && alloc_ok;
    do_loop  = !call_i && !ret_i && !alloc_i && loop_br_i && (cur.sor != '0);
    new_live = live - {1'b0, cur.sof} + {1'b0, alloc_sof_i};
    below    = live - {1'b0, cur.sof};
    sum_base = {1'b0, cur.base} + {1'b0, cur.sol};
    if (sum_base >= XW'(STACK)) sum_base = sum_base - XW'(STACK);

    cur_n  = cur;
    live_n = live;
    ovf_n  = 1'b0;
    unf_n  = 1'b0;
    if (push_o) begin
      cur_n.base = sum_base[FW-1:0];
      cur_n.sof  = cur.sof - cur.sol;
      cur_n.sol  = '0;
      cur_n.sor  = '0;
      cur_n.rrb  = '0;
    end else if (pop_o) begin
      cur_n = top_i;
      if (below < {1'b0, top_i.sol}) begin
        unf_n  = 1'b1;
        live_n = {1'b0, top_i.sof};
      end else begin
        live_n = below + {1'b0, top_i.sof} - {1'b0, top_i.sol};
      end
    end else if (do_alloc) begin
      cur_n.sof = alloc_sof_i;
      cur_n.sol = alloc_sol_i;
      cur_n.sor = rot_sz[FW-1:0];
      cur_n.rrb = '0;
      if (new_live > XW'(STACK)) begin
        ovf_n  = 1'b1;
        live_n = XW'(STACK);
      end else begin
        live_n = new_live;
      end
    end else if (do_loop) begin
      cur_n.rrb = (cur.rrb == '0) ? cur.sor - FW'(1) : cur.rrb - FW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur         <= '0;
      live        <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      cur         <= cur_n;
      live        <= live_n;
      overflow_o  <= ovf_n;
      underflow_o <= unf_n;
    end
  end

  assign cur_o = cur;

  assert_live_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (live <= XW'(STACK)) && (live >= {1'b0, cur.sof}));
  assert_rrb_range_R8: assert property (@(posedge clk) disable iff (rst)
    (cur.sor == '0) ? (cur.rrb == '0) : (cur.rrb < cur.sor));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> !$past(rst) && $past(alloc_i) && !$past(call_i) && !$past(ret_i));
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    underflow_o |-> !$past(rst) && $past(ret_i) && !$past(call_i));
  assert_call_shift_R5: assert property (@(posedge clk) disable iff (rst)
    push_o |=> (cur.sol == '0) && (cur.sor == '0) && (cur.sof == $past(cur.sof - cur.sol)));
  assert_one_op_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push_o, pop_o, do_alloc, do_loop}));
endmodule

// File: rtl/wrm_translate.sv
module wrm_translate
  import wrm_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] arch_i,
  input  logic [FW-1:0] base_i,
  input  logic [FW-1:0] sof_i,
  input  logic [FW-1:0] sor_i,
  input  logic [FW-1:0] rrb_i,
  output logic [FW-1:0] phys_o,
  output logic          illegal_o
);
  localparam int unsigned XW = FW + 1;

  logic [FW-1:0] off;
  logic [XW-1:0] rs, ps;
  logic          is_global;

  always_comb begin
    is_global = (arch_i < FW'(GLOBAL));
    off       = arch_i - FW'(GLOBAL);
    rs        = {1'b0, off};
    if (off < sor_i) begin
      rs = {1'b0, off} + {1'b0, rrb_i};
      if (rs >= {1'b0, sor_i}) rs = rs - {1'b0, sor_i};
    end
    ps = rs + {1'b0, base_i};
    if (ps >= XW'(STACK)) ps = ps - XW'(STACK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_o    <= '0;
      illegal_o <= 1'b0;
    end else if (is_global) begin
      phys_o    <= arch_i;
      illegal_o <= 1'b0;
    end else if (off >= sof_i) begin
      phys_o    <= '0;
      illegal_o <= 1'b1;
    end else begin
      phys_o    <= FW'(GLOBAL) + ps[FW-1:0];
      illegal_o <= 1'b0;
    end
  end

  assert_global_identity_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(arch_i) < FW'(GLOBAL))) |-> (phys_o == $past(arch_i)) && !illegal_o);
  assert_illegal_stacked_R3: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !$past(rst) && ($past(arch_i) >= FW'(GLOBAL)) && (phys_o == '0));
  assert_stacked_range_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(arch_i) >= FW'(GLOBAL)) && !illegal_o) |-> phys_o >= FW'(GLOBAL));
endmodule

// File: rtl/win_reg_mapper.sv
module win_reg_mapper
  import wrm_pkg::*;
#(
  parameter int unsigned FRAME_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [6:0] arch_i,
  input  logic       call_i,
  input  logic       ret_i,
  input  logic       alloc_i,
  input  logic [6:0] alloc_sof_i,
  input  logic [6:0] alloc_sol_i,
  input  logic [3:0] alloc_rot_i,
  input  logic       loop_br_i,
  output logic [6:0] phys_o,
  output logic       illegal_o,
  output logic       overflow_o,
  output logic       underflow_o
);
  frame_t cur, top;
  logic   push, pop, full, empty;

  wrm_frame_stack #(.DEPTH(FRAME_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push_i(push), .pop_i(pop), .push_data_i(cur),
    .top_o(top), .full_o(full), .empty_o(empty)
  );

  wrm_frame_ctrl u_ctrl (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i), .alloc_i(alloc_i),
    .alloc_sof_i(alloc_sof_i), .alloc_sol_i(alloc_sol_i), .alloc_rot_i(alloc_rot_i),
    .loop_br_i(loop_br_i), .full_i(full), .empty_i(empty), .top_i(top),
    .push_o(push), .pop_o(pop), .cur_o(cur),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  wrm_translate u_xlate (
    .clk(clk), .rst(rst), .arch_i(arch_i), .base_i(cur.base), .sof_i(cur.sof),
    .sor_i(cur.sor), .rrb_i(cur.rrb), .phys_o(phys_o), .illegal_o(illegal_o)
  );
endmodule

// File: tb/win_reg_mapper_tb.sv
module win_reg_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VN = 8;
  // {arch, expected phys, expected illegal} after alloc(40,16,1), rotation base 0
  localparam logic [14:0] VEC [VN] = '{
    {7'd0,   7'd0,  1'b0}, {7'd31,  7'd31, 1'b0},
    {7'd32,  7'd32, 1'b0}, {7'd39,  7'd39, 1'b0},
    {7'd40,  7'd40, 1'b0}, {7'd71,  7'd71, 1'b0},
    {7'd72,  7'd0,  1'b1}, {7'd127, 7'd0,  1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] arch_i = '0;
  logic       call_i = 0, ret_i = 0, alloc_i = 0, loop_br_i = 0;
  logic [6:0] alloc_sof_i = '0, alloc_sol_i = '0;
  logic [3:0] alloc_rot_i = '0;
  logic [6:0] phys_o;
  logic       illegal_o, overflow_o, underflow_o;
  int         n_chk = 0, n_fail = 0;
  logic       ov, un;

  always #(CLK_PERIOD / 2) clk = ~clk;

  win_reg_mapper u_dut (
    .clk(clk), .rst(rst), .arch_i(arch_i), .call_i(call_i), .ret_i(ret_i),
    .alloc_i(alloc_i), .alloc_sof_i(alloc_sof_i), .alloc_sol_i(alloc_sol_i),
    .alloc_rot_i(alloc_rot_i), .loop_br_i(loop_br_i), .phys_o(phys_o),
    .illegal_o(illegal_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [6:0] a, input int ep, input int eil, input string req);
    @(negedge clk) arch_i = a;
    @(negedge clk);
    check({req, " phys"}, int'(phys_o), ep);
    check({req, " illegal"}, int'(illegal_o), eil);
  endtask

  task automatic op(input logic c, input logic r, input logic al, input logic lb,
                    input int sof, input int sol, input int rot);
    @(negedge clk);
    call_i = c; ret_i = r; alloc_i = al; loop_br_i = lb;
    alloc_sof_i = 7'(sof); alloc_sol_i = 7'(sol); alloc_rot_i = 4'(rot);
    @(negedge clk);
    ov = overflow_o; un = underflow_o;
    call_i = 0; ret_i = 0; alloc_i = 0; loop_br_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    lookup(7'd5, 5, 0, "R12 R1 reset global");
    lookup(7'd32, 0, 1, "R12 reset stacked");

    op(0, 0, 1, 0, 40, 16, 1);
    check("R9 no overflow small alloc", int'(ov), 0);
    for (int i = 0; i < VN; i++)
      lookup(VEC[i][14:8], int'(VEC[i][7:1]), int'(VEC[i][0]), "R2 R3 R7 table");

    op(0, 0, 0, 1, 0, 0, 0);                 // rrb 0 -> 7
    lookup(7'd32, 39, 0, "R8 R7 wrap rrb7 o0");
    lookup(7'd33, 32, 0, "R7 rrb7 o1");
    lookup(7'd40, 40, 0, "R7 outside rotating");
    op(0, 0, 0, 1, 0, 0, 0);                 // rrb 6
    lookup(7'd33, 39, 0, "R8 rrb6 o1");

    op(1, 0, 0, 0, 0, 0, 0);                 // call: base16 sof24
    lookup(7'd32, 48, 0, "R5 call outputs first");
    lookup(7'd55, 71, 0, "R5 callee top");
    lookup(7'd56, 0, 1, "R5 R3 callee size");
    op(0, 0, 0, 1, 0, 0, 0);
    lookup(7'd32, 48, 0, "R8 no rotation when size zero");

    op(0, 0, 1, 0, 90, 10, 0);               // live 106
    check("R9 overflow pulse", int'(ov), 1);
    @(negedge clk);
    check("R9 overflow one cycle", int'(overflow_o), 0);
    lookup(7'd121, 41, 0, "R2 circular wrap");
    lookup(7'd127, 0, 1, "R3 beyond 90");

    op(1, 0, 0, 0, 0, 0, 0);                 // base26 sof80
    lookup(7'd111, 41, 0, "R5 R2 nested wrap");
    op(0, 0, 1, 0, 80, 80, 0);
    check("R9 exact fill no overflow", int'(ov), 0);

    op(0, 1, 0, 0, 0, 0, 0);
    check("R10 no underflow resident", int'(un), 0);
    lookup(7'd121, 41, 0, "R6 restore frame");
    op(0, 1, 0, 0, 0, 0, 0);
    check("R10 underflow pulse", int'(un), 1);
    lookup(7'd33, 39, 0, "R6 restore rotation base");
    op(0, 1, 0, 0, 0, 0, 0);
    check("R6 empty return no underflow", int'(un), 0);
    lookup(7'd33, 39, 0, "R6 empty return ignored");

    op(0, 0, 1, 0, 20, 30, 0);
    lookup(7'd71, 71, 0, "R4 reject locals over size");
    op(0, 0, 1, 0, 16, 0, 3);
    lookup(7'd71, 71, 0, "R4 reject rotation over size");
    op(0, 0, 1, 0, 97, 0, 0);
    lookup(7'd71, 71, 0, "R4 reject size over stack");

    op(1, 1, 1, 0, 8, 0, 0);
    lookup(7'd32, 48, 0, "R11 call beats return and alloc");
    lookup(7'd56, 0, 1, "R11 call size");
    op(0, 1, 0, 0, 0, 0, 0);
    lookup(7'd33, 39, 0, "R11 return after priority call");
    op(0, 0, 1, 1, 40, 16, 1);
    lookup(7'd33, 33, 0, "R11 R4 alloc beats loop, rrb cleared");

    do_reset();
    lookup(7'd32, 0, 1, "R12 reset clears frame");
    for (int i = 0; i < 9; i++) begin
      op(0, 0, 1, 0, 8, 1, 0);
      op(1, 0, 0, 0, 0, 0, 0);
    end
    lookup(7'd32, 40, 0, "R5 ninth call ignored base");
    lookup(7'd39, 47, 0, "R5 ninth call ignored size");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule